// File: doc/BRIEF.md
# Address Translation Sequencer and Fault Encoder

This block orders the steps of one address translation and turns the outcome into either a real address with access rights or a fully encoded fault. A request carries an effective address, an access kind (fetch, load or store), an access class (integer, floating point, reservation, cache operation or external control), the privilege level and whether translation is on. The sequencer works through these steps in a fixed order, stopping at the first one that decides the outcome:

1. Real mode.
2. A block-translation lookup through an external matcher.
3. The attributes of the segment picked by the top four address bits.
4. Direct-store segment handling.
5. Segment no-execute.
6. A page-table walk through an external walker.
7. The final rights check.

The matcher and walker are neighbours reached through a level request and a one-cycle done pulse. Each of them sees the latched effective address on `xl_ea`. The segment attributes arrive as four flags selected by `seg_idx`. The result is a one-cycle `rsp_valid` pulse. The response fields hold their values until the next result.

Protection is a 3-bit vector: bit 0 is read, bit 1 is write, bit 2 is execute. Access kind codes are 0 for fetch, 1 for load and 2 for store. Class codes are 0 for integer, 1 for float, 2 for reservation, 3 for cache operation and 4 for external control. Codes 5 to 7 count as integer. The exception kind codes are 0 for none, 1 for instruction fault, 2 for data fault and 3 for alignment. The segment flags are:

| Bit of `seg_attr` | Meaning |
|---|---|
| 3 | Direct-store segment |
| 2 | Supervisor key |
| 1 | User key |
| 0 | No-execute |

The key in force is the user key for user requests and the supervisor key otherwise.

Top module: `xlat_sequencer`

## Requirements
- R1: With translation off, the response is a success with the real address equal to the effective address and rights 3'b111. It comes one cycle after acceptance and makes no matcher or walker request.
- R2: With translation on, the matcher is always asked first. On a hit whose rights allow the access, the real address is the matcher page frame joined with the page offset and the rights are the matcher rights, whatever the segment flags say. Fetch needs execute, load needs read and store needs write.
- R3: A matcher hit whose rights forbid the access is a permission fault. It gives instruction code 0x08000000 for a fetch, and data status 0x08000000 for a load or 0x0A000000 for a store.
- R4: A fetch to a direct-store or no-execute segment, after a matcher miss, gives an instruction fault with code 0x10000000 and no walk.
- R5: A walk miss gives instruction code 0x40000000 for a fetch, and data status 0x40000000 for a load or 0x42000000 for a store.
- R6: On a walk hit, the rights come from the key and the 2-bit page protection. With key 0, values 0 to 2 give read/write and 3 gives read-only. With key 1, value 0 gives none, 1 and 3 give read-only and 2 gives read/write. Execute equals read unless the segment is no-execute. On success, the real address is the walker page frame joined with the page offset.
- R7: A walk hit whose rights forbid the access gives the same codes as R3.
- R8: A float access to a direct-store segment gives an alignment fault with status 0.
- R9: A reservation access to a direct-store segment gives a data fault with status 0x04000000 for a load or 0x06000000 for a store.
- R10: An external-control access to a direct-store segment gives a data fault with status 0x04100000 for a load or 0x06100000 for a store.
- R11: A cache-operation access to a direct-store segment succeeds with the real address equal to the effective address. Its rights are read/write under key 1 and read-only under key 0.
- R12: An integer access to a direct-store segment gets read/write rights under key 1 and read-only under key 0. When those rights allow it, the access succeeds untranslated; otherwise it is a permission fault coded as in R3.
- R13: On every data or alignment fault, the data address output holds the effective address. All fields that do not apply to the response are zero: instruction code on data faults, status and address on instruction faults, everything on success, and address and rights on any fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind |
| req_class | input | 3 | Access class |
| req_user | input | 1 | User-mode request |
| req_xlat_en | input | 1 | Translation enabled |
| xl_ea | output | 32 | Latched effective address for the neighbours |
| seg_idx | output | 4 | Segment selector (top address bits) |
| seg_attr | input | 4 | Selected segment flags |
| bat_req | output | 1 | Matcher request (level) |
| bat_done | input | 1 | Matcher answer strobe |
| bat_hit | input | 1 | Matcher hit |
| bat_prot | input | 3 | Matcher rights |
| bat_pfn | input | 20 | Matcher page frame |
| walk_req | output | 1 | Walker request (level) |
| walk_done | input | 1 | Walker answer strobe |
| walk_hit | input | 1 | Walker found an entry |
| walk_pp | input | 2 | Entry page protection |
| walk_pfn | input | 20 | Entry page frame |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_ra | output | 32 | Real address |
| rsp_prot | output | 3 | Granted rights |
| rsp_exc | output | 2 | Exception kind |
| rsp_icode | output | 32 | Instruction fault code |
| rsp_dsr | output | 32 | Data status value |
| rsp_dar | output | 32 | Data address value |

## Verification
The hardest outcomes to reach are the ones that need several neighbours to answer in one particular way at once. Examples are a direct-store segment reached only after a matcher miss, a walk hit whose key and page protection forbid a store but allow a load, and a matcher hit that must win over a direct-store or no-execute segment. The bench plays both the matcher and the walker, with random answer delays. It draws the hit flags, rights, protection values and segment flags at random alongside the kind and class, so every combination of those steps is visited. Directed cases pin the exact status words for each class and direction.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // access kinds
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // access classes
  localparam logic [2:0] CLS_INT   = 3'd0;
  localparam logic [2:0] CLS_FLOAT = 3'd1;
  localparam logic [2:0] CLS_RESV  = 3'd2;
  localparam logic [2:0] CLS_CACHE = 3'd3;
  localparam logic [2:0] CLS_EXT   = 3'd4;

  // exception kinds
  localparam logic [1:0] EXC_NONE  = 2'd0;
  localparam logic [1:0] EXC_INST  = 2'd1;
  localparam logic [1:0] EXC_DATA  = 2'd2;
  localparam logic [1:0] EXC_ALIGN = 2'd3;

  // rights bit positions
  localparam int PR_R = 0;
  localparam int PR_W = 1;
  localparam int PR_X = 2;

  // segment flag positions
  localparam int SEG_NX = 0;
  localparam int SEG_KU = 1;
  localparam int SEG_KS = 2;
  localparam int SEG_DS = 3;

  localparam int SW = 32;
  localparam logic [SW-1:0] ST_NOEXEC  = 32'h1000_0000;
  localparam logic [SW-1:0] ST_MISS    = 32'h4000_0000;
  localparam logic [SW-1:0] ST_MISS_W  = 32'h4200_0000;
  localparam logic [SW-1:0] ST_PERM    = 32'h0800_0000;
  localparam logic [SW-1:0] ST_PERM_W  = 32'h0A00_0000;
  localparam logic [SW-1:0] ST_RESV    = 32'h0400_0000;
  localparam logic [SW-1:0] ST_RESV_W  = 32'h0600_0000;
  localparam logic [SW-1:0] ST_EXT     = 32'h0410_0000;
  localparam logic [SW-1:0] ST_EXT_W   = 32'h0610_0000;

  typedef enum logic [2:0] {
    CS_NONE, CS_NOEXEC, CS_MISS, CS_PERM, CS_ALIGN, CS_RESV, CS_EXT
  } cause_e;

  typedef enum logic [1:0] {S_IDLE, S_BAT, S_WALK} seq_state_e;

  function automatic logic access_ok(input logic [2:0] prot, input logic [1:0] kind);
    case (kind)
      ACC_FETCH: access_ok = prot[PR_X];
      ACC_STORE: access_ok = prot[PR_W];
      default:   access_ok = prot[PR_R];
    endcase
  endfunction

endpackage

// File: rtl/xlat_rights.sv
module xlat_rights
  import xlat_pkg::*;
(
  input  logic       key,
  input  logic [1:0] pp,
  input  logic       nx,
  output logic [2:0] prot
);
  logic rd, wr;

  always_comb begin
    if (!key) begin
      rd = 1'b1;
      wr = (pp != 2'd3);
    end else begin
      rd = (pp != 2'd0);
      wr = (pp == 2'd2);
    end
    prot        = '0;
    prot[PR_R]  = rd;
    prot[PR_W]  = wr;
    prot[PR_X]  = rd & ~nx;
  end
endmodule

// File: rtl/xlat_dstore.sv
module xlat_dstore
  import xlat_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [2:0] cls,
  input  logic       key,
  output logic       ok,
  output cause_e     cause,
  output logic [2:0] prot
);
  logic [2:0] key_prot;

  always_comb begin
    key_prot       = '0;
    key_prot[PR_R] = 1'b1;
    key_prot[PR_W] = key;
    ok    = 1'b0;
    cause = CS_NONE;
    prot  = '0;
    if (kind == ACC_FETCH) begin
      cause = CS_NOEXEC;
    end else begin
      case (cls)
        CLS_FLOAT: cause = CS_ALIGN;
        CLS_RESV:  cause = CS_RESV;
        CLS_EXT:   cause = CS_EXT;
        CLS_CACHE: begin
          ok   = 1'b1;
          prot = key_prot;
        end
        default: begin
          if (access_ok(key_prot, kind)) begin
            ok   = 1'b1;
            prot = key_prot;
          end else begin
            cause = CS_PERM;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xlat_fault_enc.sv
module xlat_fault_enc
  import xlat_pkg::*;
#(
  parameter int AW = 32
) (
  input  cause_e          cause,
  input  logic [1:0]      kind,
  input  logic [AW-1:0]   ea,
  output logic [1:0]      exc,
  output logic [SW-1:0]   icode,
  output logic [SW-1:0]   dsr,
  output logic [AW-1:0]   dar
);
  logic st;
  logic fetch;

  assign st    = (kind == ACC_STORE);
  assign fetch = (kind == ACC_FETCH);

  always_comb begin
    exc   = EXC_NONE;
    icode = '0;
    dsr   = '0;
    dar   = '0;
    case (cause)
      CS_NOEXEC: begin
        exc   = EXC_INST;
        icode = ST_NOEXEC;
      end
      CS_MISS, CS_PERM: begin
        if (fetch) begin
          exc   = EXC_INST;
          icode = (cause == CS_MISS) ? ST_MISS : ST_PERM;
        end else begin
          exc = EXC_DATA;
          dar = ea;
          if (cause == CS_MISS) dsr = st ? ST_MISS_W : ST_MISS;
          else                  dsr = st ? ST_PERM_W : ST_PERM;
        end
      end
      CS_ALIGN: begin
        exc = EXC_ALIGN;
        dar = ea;
      end
      CS_RESV: begin
        exc = EXC_DATA;
        dar = ea;
        dsr = st ? ST_RESV_W : ST_RESV;
      end
      CS_EXT: begin
        exc = EXC_DATA;
        dar = ea;
        dsr = st ? ST_EXT_W : ST_EXT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xlat_sequencer.sv
module xlat_sequencer
  import xlat_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_W     = 4,
  localparam int PFN_W    = AW - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_ea,
  input  logic [1:0]       req_kind,
  input  logic [2:0]       req_class,
  input  logic             req_user,
  input  logic             req_xlat_en,
  output logic [AW-1:0]    xl_ea,
  output logic [SEG_W-1:0] seg_idx,
  input  logic [3:0]       seg_attr,
  output logic             bat_req,
  input  logic             bat_done,
  input  logic             bat_hit,
  input  logic [2:0]       bat_prot,
  input  logic [PFN_W-1:0] bat_pfn,
  output logic             walk_req,
  input  logic             walk_done,
  input  logic             walk_hit,
  input  logic [1:0]       walk_pp,
  input  logic [PFN_W-1:0] walk_pfn,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [AW-1:0]    rsp_ra,
  output logic [2:0]       rsp_prot,
  output logic [1:0]       rsp_exc,
  output logic [SW-1:0]    rsp_icode,
  output logic [SW-1:0]    rsp_dsr,
  output logic [AW-1:0]    rsp_dar
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  seq_state_e       st_q, st_n;
  logic [AW-1:0]    lat_ea;
  logic [1:0]       lat_kind;
  logic [2:0]       lat_cls;
  logic             lat_user;
  logic             lat_en;

  logic [AW-1:0]    cur_ea;
  logic [1:0]       cur_kind;
  logic             key;

  logic             fin;
  logic [AW-1:0]    fin_ra;
  logic [2:0]       fin_prot;
  cause_e           fin_cause;

  logic             ds_ok;
  cause_e           ds_cause;
  logic [2:0]       ds_prot;
  logic [2:0]       wk_prot;

  logic [1:0]       enc_exc;
  logic [SW-1:0]    enc_icode, enc_dsr;
  logic [AW-1:0]    enc_dar;

  assign lat_en   = (st_q == S_IDLE) && req_valid;
  assign cur_ea   = (st_q == S_IDLE) ? req_ea   : lat_ea;
  assign cur_kind = (st_q == S_IDLE) ? req_kind : lat_kind;
  assign key      = lat_user ? seg_attr[SEG_KU] : seg_attr[SEG_KS];

  assign xl_ea    = lat_ea;
  assign seg_idx  = lat_ea[AW-1 -: SEG_W];
  assign bat_req  = (st_q == S_BAT);
  assign walk_req = (st_q == S_WALK);

  xlat_dstore u_ds (
    .kind  (lat_kind),
    .cls   (lat_cls),
    .key   (key),
    .ok    (ds_ok),
    .cause (ds_cause),
    .prot  (ds_prot)
  );

  xlat_rights u_rt (
    .key  (key),
    .pp   (walk_pp),
    .nx   (seg_attr[SEG_NX]),
    .prot (wk_prot)
  );

  xlat_fault_enc #(.AW(AW)) u_enc (
    .cause (fin_cause),
    .kind  (cur_kind),
    .ea    (cur_ea),
    .exc   (enc_exc),
    .icode (enc_icode),
    .dsr   (enc_dsr),
    .dar   (enc_dar)
  );

  // next-state and step decisions
  always_comb begin
    st_n      = st_q;
    fin       = 1'b0;
    fin_ra    = '0;
    fin_prot  = '0;
    fin_cause = CS_NONE;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          if (!req_xlat_en) begin
            fin      = 1'b1;
            fin_ra   = req_ea;
            fin_prot = 3'b111;
          end else begin
            st_n = S_BAT;
          end
        end
      end
      S_BAT: begin
        if (bat_done) begin
          if (bat_hit) begin
            fin = 1'b1;
            if (access_ok(bat_prot, lat_kind)) begin
              fin_ra   = {bat_pfn, lat_ea[PAGE_BITS-1:0]};
              fin_prot = bat_prot;
            end else begin
              fin_cause = CS_PERM;
            end
          end else if (seg_attr[SEG_DS]) begin
            fin = 1'b1;
            if (ds_ok) begin
              fin_ra   = lat_ea;
              fin_prot = ds_prot;
            end else begin
              fin_cause = ds_cause;
            end
          end else if (lat_kind == ACC_FETCH && seg_attr[SEG_NX]) begin
            fin       = 1'b1;
            fin_cause = CS_NOEXEC;
          end else begin
            st_n = S_WALK;
          end
        end
      end
      S_WALK: begin
        if (walk_done) begin
          fin = 1'b1;
          if (!walk_hit) begin
            fin_cause = CS_MISS;
          end else if (access_ok(wk_prot, lat_kind)) begin
            fin_ra   = {walk_pfn, lat_ea[PAGE_BITS-1:0]};
            fin_prot = wk_prot;
          end else begin
            fin_cause = CS_PERM;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (fin) st_n = S_IDLE;
  end

  // state and request latch
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      st_q     <= S_IDLE;
      lat_ea   <= '0;
      lat_kind <= '0;
      lat_cls  <= '0;
      lat_user <= 1'b0;
    end else begin
      st_q <= st_n;
      if (lat_en) begin
        lat_ea   <= req_ea;
        lat_kind <= req_kind;
        lat_cls  <= req_class;
        lat_user <= req_user;
      end
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ra    <= '0;
      rsp_prot  <= '0;
      rsp_exc   <= EXC_NONE;
      rsp_icode <= '0;
      rsp_dsr   <= '0;
      rsp_dar   <= '0;
    end else begin
      rsp_valid <= fin;
      if (fin) begin
        rsp_fault <= (fin_cause != CS_NONE);
        rsp_ra    <= fin_ra;
        rsp_prot  <= fin_prot;
        rsp_exc   <= enc_exc;
        rsp_icode <= enc_icode;
        rsp_dsr   <= enc_dsr;
        rsp_dar   <= enc_dar;
      end
    end
  end

endmodule

// File: rtl/xlat_sequencer_chk.sv
module xlat_sequencer_chk
  import xlat_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] xl_ea,
  input logic          bat_req,
  input logic          walk_req,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [AW-1:0] rsp_ra,
  input logic [2:0]    rsp_prot,
  input logic [1:0]    rsp_exc,
  input logic [SW-1:0] rsp_icode,
  input logic [SW-1:0] rsp_dsr,
  input logic [AW-1:0] rsp_dar
);

  // R1: a response not preceded by a neighbour request is real mode
  a_r1_real_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(!bat_req && !walk_req) |->
      !rsp_fault && rsp_ra == xl_ea && rsp_prot == 3'b111);

  // R2: the walk is only ever entered after the matcher answered
  a_r2_matcher_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req) |-> $past(bat_req));

  // R2: never both neighbours at once
  a_r2_one_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
    !(bat_req && walk_req));

  // R13: data and alignment faults carry the effective address
  a_r13_dar_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_exc == EXC_DATA || rsp_exc == EXC_ALIGN) |->
      rsp_dar == xl_ea && rsp_icode == '0);

  // R13: instruction faults leave data fields clear
  a_r13_inst_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_exc == EXC_INST |-> rsp_dsr == '0 && rsp_dar == '0);

  // R13: success carries no exception fields; fault carries no address
  a_r13_success_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_exc == EXC_NONE && rsp_icode == '0 && rsp_dsr == '0);

  a_r13_fault_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_exc != EXC_NONE && rsp_ra == '0 && rsp_prot == '0);

  // R8: alignment fault has zero status
  a_r8_align_status: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_exc == EXC_ALIGN |-> rsp_dsr == '0);

endmodule

bind xlat_sequencer xlat_sequencer_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ok_n),
  .xl_ea     (xl_ea),
  .bat_req   (bat_req),
  .walk_req  (walk_req),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_ra    (rsp_ra),
  .rsp_prot  (rsp_prot),
  .rsp_exc   (rsp_exc),
  .rsp_icode (rsp_icode),
  .rsp_dsr   (rsp_dsr),
  .rsp_dar   (rsp_dar)
);

// File: tb/sim_xlat_sequencer.sv
`timescale 1ns/1ps
module sim_xlat_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_class = '0;
  logic        req_user = 1'b0;
  logic        req_xlat_en = 1'b0;
  logic [31:0] xl_ea;
  logic [3:0]  seg_idx;
  logic [3:0]  seg_attr = '0;
  logic        bat_req, walk_req;
  logic        bat_done = 1'b0, bat_hit = 1'b0;
  logic [2:0]  bat_prot = '0;
  logic [19:0] bat_pfn = '0;
  logic        walk_done = 1'b0, walk_hit = 1'b0;
  logic [1:0]  walk_pp = '0;
  logic [19:0] walk_pfn = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_ra;
  logic [2:0]  rsp_prot;
  logic [1:0]  rsp_exc;
  logic [31:0] rsp_icode, rsp_dsr, rsp_dar;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  xlat_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_kind(req_kind), .req_class(req_class), .req_user(req_user),
    .req_xlat_en(req_xlat_en), .xl_ea(xl_ea), .seg_idx(seg_idx),
    .seg_attr(seg_attr), .bat_req(bat_req), .bat_done(bat_done),
    .bat_hit(bat_hit), .bat_prot(bat_prot), .bat_pfn(bat_pfn),
    .walk_req(walk_req), .walk_done(walk_done), .walk_hit(walk_hit),
    .walk_pp(walk_pp), .walk_pfn(walk_pfn), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_ra(rsp_ra), .rsp_prot(rsp_prot),
    .rsp_exc(rsp_exc), .rsp_icode(rsp_icode), .rsp_dsr(rsp_dsr),
    .rsp_dar(rsp_dar)
  );

  typedef struct packed {
    logic        fault;
    logic [1:0]  exc;
    logic [31:0] ra;
    logic [2:0]  prot;
    logic [31:0] icode;
    logic [31:0] dsr;
    logic [31:0] dar;
    logic        bat;
    logic        walk;
  } res_t;

  function automatic logic allowed(input logic [2:0] p, input logic [1:0] k);
    if (k == 2'd0) return p[2];
    if (k == 2'd2) return p[1];
    return p[0];
  endfunction

  // cause codes: 0 ok,1 noexec,2 miss,3 perm,4 align,5 resv,6 ext
  function automatic res_t model(input logic xen, input logic [1:0] k,
      input logic [2:0] cls, input logic usr, input logic [31:0] ea,
      input logic bh, input logic [2:0] bp, input logic [19:0] bf,
      input logic [3:0] sg, input logic wh, input logic [1:0] pp,
      input logic [19:0] wf, output string tag);
    res_t r;
    int cause;
    logic key, rd, wr;
    logic [2:0] p;
    r = '0;
    cause = 0;
    key = usr ? sg[1] : sg[2];
    if (!xen) begin
      tag = "R1"; r.ra = ea; r.prot = 3'b111;
    end else begin
      r.bat = 1'b1;
      if (bh) begin
        if (allowed(bp, k)) begin tag = "R2"; r.ra = {bf, ea[11:0]}; r.prot = bp; end
        else begin tag = "R3"; cause = 3; end
      end else if (sg[3]) begin
        p = {1'b0, key, 1'b1};
        if (k == 2'd0) begin tag = "R4"; cause = 1; end
        else if (cls == 3'd1) begin tag = "R8"; cause = 4; end
        else if (cls == 3'd2) begin tag = "R9"; cause = 5; end
        else if (cls == 3'd4) begin tag = "R10"; cause = 6; end
        else if (cls == 3'd3) begin tag = "R11"; r.ra = ea; r.prot = p; end
        else begin
          tag = "R12";
          if (allowed(p, k)) begin r.ra = ea; r.prot = p; end
          else cause = 3;
        end
      end else if (k == 2'd0 && sg[0]) begin
        tag = "R4"; cause = 1;
      end else begin
        r.walk = 1'b1;
        if (!wh) begin tag = "R5"; cause = 2; end
        else begin
          rd = key ? (pp != 2'd0) : 1'b1;
          wr = key ? (pp == 2'd2) : (pp != 2'd3);
          p = {rd & ~sg[0], wr, rd};
          if (allowed(p, k)) begin tag = "R6"; r.ra = {wf, ea[11:0]}; r.prot = p; end
          else begin tag = "R7"; cause = 3; end
        end
      end
    end
    r.fault = (cause != 0);
    case (cause)
      1: begin r.exc = 2'd1; r.icode = 32'h1000_0000; end
      2: if (k == 2'd0) begin r.exc = 2'd1; r.icode = 32'h4000_0000; end
         else begin r.exc = 2'd2; r.dar = ea; r.dsr = (k == 2'd2) ? 32'h4200_0000 : 32'h4000_0000; end
      3: if (k == 2'd0) begin r.exc = 2'd1; r.icode = 32'h0800_0000; end
         else begin r.exc = 2'd2; r.dar = ea; r.dsr = (k == 2'd2) ? 32'h0A00_0000 : 32'h0800_0000; end
      4: begin r.exc = 2'd3; r.dar = ea; end
      5: begin r.exc = 2'd2; r.dar = ea; r.dsr = (k == 2'd2) ? 32'h0600_0000 : 32'h0400_0000; end
      6: begin r.exc = 2'd2; r.dar = ea; r.dsr = (k == 2'd2) ? 32'h0610_0000 : 32'h0410_0000; end
      default: ;
    endcase
    if (cause != 0 && tag != "R4" && tag != "R8" && r.exc == 2'd2 && r.dar != ea) tag = "R13";
    return r;
  endfunction

  task automatic run(input logic xen, input logic [1:0] k, input logic [2:0] cls,
      input logic usr, input logic [31:0] ea, input logic bh, input logic [2:0] bp,
      input logic [19:0] bf, input logic [3:0] sg, input logic wh,
      input logic [1:0] pp, input logic [19:0] wf, input int dly);
    res_t e, a;
    string tag;
    bit got = 0;
    int wait_b = dly, wait_w = dly;
    e = model(xen, k, cls, usr, ea, bh, bp, bf, sg, wh, pp, wf, tag);
    a = '0;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_kind = k; req_class = cls;
    req_user = usr; req_xlat_en = xen; seg_attr = sg;
    bat_hit = bh; bat_prot = bp; bat_pfn = bf;
    walk_hit = wh; walk_pp = pp; walk_pfn = wf;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      bat_done = 1'b0;
      walk_done = 1'b0;
      if (rsp_valid) begin
        got = 1;
        a.fault = rsp_fault; a.exc = rsp_exc; a.ra = rsp_ra; a.prot = rsp_prot;
        a.icode = rsp_icode; a.dsr = rsp_dsr; a.dar = rsp_dar;
        break;
      end
      if (bat_req) begin
        a.bat = 1'b1;
        if (wait_b == 0) bat_done = 1'b1; else wait_b--;
      end
      if (walk_req) begin
        a.walk = 1'b1;
        if (wait_w == 0) walk_done = 1'b1; else wait_w--;
      end
    end
    n_tests++;
    if (!got) begin
      n_fail++;
      $display("FAIL %s watchdog: no response, actual none expected %h", tag, e);
    end else if (a !== e) begin
      n_fail++;
      $display("FAIL %s ea=%h kind=%0d cls=%0d actual %h expected %h", tag, ea, k, cls, a, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state (R13)
    n_tests++;
    if (rsp_valid !== 1'b0 || bat_req !== 1'b0 || walk_req !== 1'b0 || rsp_exc !== 2'd0) begin
      n_fail++;
      $display("FAIL R13 reset state actual %b%b%b%0d expected 0000", rsp_valid, bat_req, walk_req, rsp_exc);
    end
    // R1 real mode
    run(0, 2'd2, 3'd0, 1, 32'hDEAD_BEEF, 1, 3'b000, 20'h1, 4'hF, 0, 2'd0, 20'h2, 0);
    // R2 matcher hit beats direct-store segment
    run(1, 2'd1, 3'd1, 0, 32'h3000_0ABC, 1, 3'b001, 20'hABCDE, 4'b1000, 1, 2'd2, 20'h1, 2);
    // R3 matcher hit, store without write
    run(1, 2'd2, 3'd0, 0, 32'h1234_5678, 1, 3'b101, 20'h5, 4'b0000, 1, 2'd2, 20'h1, 0);
    run(1, 2'd0, 3'd0, 0, 32'h1234_5678, 1, 3'b011, 20'h5, 4'b0000, 1, 2'd2, 20'h1, 0);
    // R4 fetch to direct-store and to no-execute segment
    run(1, 2'd0, 3'd0, 0, 32'h8000_0010, 0, 3'b000, 20'h0, 4'b1110, 1, 2'd2, 20'h1, 1);
    run(1, 2'd0, 3'd0, 0, 32'h8000_0010, 0, 3'b000, 20'h0, 4'b0001, 1, 2'd2, 20'h1, 0);
    // R5 walk miss, each direction
    run(1, 2'd0, 3'd0, 0, 32'h4000_1000, 0, 3'b0, 20'h0, 4'b0000, 0, 2'd0, 20'h0, 3);
    run(1, 2'd1, 3'd0, 0, 32'h4000_1004, 0, 3'b0, 20'h0, 4'b0000, 0, 2'd0, 20'h0, 0);
    run(1, 2'd2, 3'd0, 0, 32'h4000_1008, 0, 3'b0, 20'h0, 4'b0000, 0, 2'd0, 20'h0, 1);
    // R6 walk hit, key 1, pp 1 load ok; R7 same store fails
    run(1, 2'd1, 3'd0, 1, 32'h5555_5123, 0, 3'b0, 20'h0, 4'b0010, 1, 2'd1, 20'h77777, 0);
    run(1, 2'd2, 3'd0, 1, 32'h5555_5123, 0, 3'b0, 20'h0, 4'b0010, 1, 2'd1, 20'h77777, 0);
    run(1, 2'd1, 3'd0, 1, 32'h5555_5123, 0, 3'b0, 20'h0, 4'b0010, 1, 2'd0, 20'h77777, 0);
    // R8..R12 direct-store classes
    run(1, 2'd2, 3'd1, 0, 32'h9000_0004, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd1, 3'd2, 0, 32'h9000_0008, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd2, 3'd2, 0, 32'h9000_0008, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd1, 3'd4, 0, 32'h9000_000C, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd2, 3'd4, 0, 32'h9000_000C, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd2, 3'd3, 1, 32'h9000_0010, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd2, 3'd0, 1, 32'h9000_0014, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd2, 3'd0, 0, 32'h9000_0014, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    run(1, 2'd1, 3'd0, 1, 32'h9000_0018, 0, 3'b0, 20'h0, 4'b1100, 0, 2'd0, 20'h0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      run(rv[0] | rv[1], 2'($urandom_range(0, 2)), 3'($urandom_range(0, 5)), rv[2],
          $urandom, rv[3] & rv[4], rv[7:5], 20'($urandom), rv[11:8], rv[12] | rv[13],
          rv[15:14], 20'($urandom), int'(rv[17:16]));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule